// File: doc/BRIEF.md
# Rail Response Bit Receiver

This block collects a short serial reply that a device on a powered rail sends back after a command packet. A one-cycle start pulse marks the end of the outgoing packet. The block then keeps the rail powered for a fixed holdoff. After that it runs a train of equally spaced bit slots. In each slot it drops rail power, waits a settle time, reads the rail-detect input, and then brings power back. Each bit it reads is shifted into a response word.

The first bit read must be a start bit, a logic 1. If it is a logic 0, no device is answering: the block gives up at once and flags an abort. Otherwise it keeps reading until a fixed number of bits have arrived. On the last bit it restores power straight after the sample. Both endings raise a one-cycle done pulse. The response word, the bit count and the abort flag stay unchanged until the next start pulse.

All timing is given in clock cycles through parameters. With a 2 MHz clock, the defaults give a 2.3 ms holdoff, 250 µs slots, 28 µs settle and a 20 µs restore delay. The detect input is asynchronous and passes through a synchronizer of `SYNC_STAGES` flops, so `SAMPLE_CYC` must exceed `SYNC_STAGES`. `SAMPLE_CYC + RESTORE_CYC` must be less than `SLOT_CYC`. The response word has no back-pressure: a consumer takes it on the done pulse, or at any time before the next start, because it holds until then.

Top module: `rail_resp_rx`

## Requirements
- R1: After reset, rail power is on (`rail_pwr_o`=1), `done_o` and `abort_o` are 0, and `resp_o` and `len_o` are 0.
- R2: A start pulse clears the response, the length and the abort flag, keeps rail power on, and restarts the holdoff. This also applies when a start pulse arrives in the middle of a reception.
- R3: Rail power first drops `DELAY_CYC`+1 cycles after the clock edge at which the start pulse is taken (by the bench's cycle count). Later drops follow every `SLOT_CYC` cycles.
- R4: In each slot, detect is read once rail power has been low for `SAMPLE_CYC` cycles. A high detect level counts as bit 0 and a low level as bit 1.
- R5: Each bit that is accepted shifts `resp_o` left, with the new bit going into bit 0, and adds one to `len_o`. The first bit received therefore ends up as the most significant received bit.
- R6: When more bits remain to be read, rail power stays low for `SAMPLE_CYC`+`RESTORE_CYC` cycles in each slot.
- R7: If a bit 0 is read while the response is still all zeros, the block aborts. `abort_o` rises, `done_o` pulses, rail power comes back after only `SAMPLE_CYC` low cycles, and `resp_o` and `len_o` stay 0.
- R8: When bit number `MAX_BITS` is read, rail power comes back after only `SAMPLE_CYC` low cycles, `done_o` pulses, `len_o` equals `MAX_BITS`, and no further slot starts.
- R9: `done_o` is high for exactly one cycle per reception. After it, `resp_o`, `len_o` and `abort_o` hold until the next start pulse.
- R10: `len_o` never exceeds `MAX_BITS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse: the outgoing packet has ended |
| det_i | input | 1 | Rail-detect level (asynchronous); low means logic 1 |
| rail_pwr_o | output | 1 | 1 = rail powered, 0 = rail pulled low for a bit slot |
| resp_o | output | MAX_BITS | Received response, first bit at the top |
| len_o | output | LEN_W | Number of bits received |
| done_o | output | 1 | One-cycle pulse when a reception ends |
| abort_o | output | 1 | Set when reception ended with no start bit |

## Verification
The hardest case to reach from the ports is a detect level that changes inside each slot in step with the block's own power-down. A fixed input cannot produce a mix of 0s and 1s. The bench therefore models the rail: while power is on, detect is high, and while power is off, detect follows the next bit of a chosen reply pattern. The bench then sweeps all 64 reply patterns of a 6-bit configuration, so it covers both the abort path and the full-length path with every mix of bits after the start bit. It also restarts the block partway through a reception.

// File: rtl/rrx_pkg.sv
package rrx_pkg;

  // Phases of one reception.
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,   // rail powered, results held
    RX_WAIT = 2'd1,   // holdoff after the outgoing packet
    RX_SLOT = 2'd2    // inside a bit slot
  } rx_state_e;

  // Bits needed to count from 0 to (the larger of a and b) - 1.
  function automatic int unsigned span_bits(int unsigned a, int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/rrx_sync.sv
module rrx_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else if (STAGES == 1) begin : g_single
      logic ff_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= RESET_VAL;
        else        ff_q <= d_i;
      end
      assign q_o = ff_q;
    end else begin : g_chain
      logic [STAGES-1:0] ff_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= {STAGES{RESET_VAL}};
        else        ff_q <= {ff_q[STAGES-2:0], d_i};
      end
      assign q_o = ff_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/rrx_timer.sv
module rrx_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o
);

  logic [CW-1:0] cnt_q;

  // Clearing takes priority over counting.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/rrx_shifter.sv
module rrx_shifter #(
  parameter int unsigned N  = 15,
  parameter int unsigned LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [N-1:0]  resp_o,
  output logic [LW-1:0] len_o,
  output logic          empty_o,
  output logic          last_o
);

  logic [N-1:0]  resp_q;
  logic [LW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q <= '0;
      len_q  <= '0;
    end else if (clr_i) begin
      resp_q <= '0;
      len_q  <= '0;
    end else if (shift_i) begin
      resp_q <= {resp_q[N-2:0], bit_i};
      len_q  <= len_q + LW'(1);
    end
  end

  assign resp_o  = resp_q;
  assign len_o   = len_q;
  assign empty_o = (resp_q == '0);
  assign last_o  = (len_q == LW'(N - 1));

endmodule

// File: rtl/rail_resp_rx.sv
module rail_resp_rx
  import rrx_pkg::*;
#(
  parameter int unsigned DELAY_CYC   = 4600,
  parameter int unsigned SLOT_CYC    = 500,
  parameter int unsigned SAMPLE_CYC  = 56,
  parameter int unsigned RESTORE_CYC = 40,
  parameter int unsigned MAX_BITS    = 15,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LEN_W      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                det_i,
  output logic                rail_pwr_o,
  output logic [MAX_BITS-1:0] resp_o,
  output logic [LEN_W-1:0]    len_o,
  output logic                done_o,
  output logic                abort_o
);

  localparam int unsigned CW = span_bits(DELAY_CYC, SLOT_CYC);
  localparam logic [CW-1:0] WAIT_LAST   = CW'(DELAY_CYC - 1);
  localparam logic [CW-1:0] SLOT_LAST   = CW'(SLOT_CYC - 1);
  localparam logic [CW-1:0] SAMPLE_AT   = CW'(SAMPLE_CYC - 1);
  localparam logic [CW-1:0] LOW_CYCLES  = CW'(SAMPLE_CYC + RESTORE_CYC);

  rx_state_e     state_q, state_d;
  logic [CW-1:0] cnt;
  logic          det_s;
  logic          rx_bit;
  logic          sample_pt, wait_end, slot_end;
  logic          abort_now, full_now, shift_en;
  logic          resp_empty, resp_last;
  logic          tmr_clr, tmr_en;
  logic          done_q, abort_q;

  // Synchronizer for the asynchronous detect level. It resets to high,
  // which is the idle level and reads as logic 0.
  rrx_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (det_i),
    .q_o   (det_s)
  );

  // A low detect level means logic 1.
  assign rx_bit = ~det_s;

  // Events within the holdoff and within a slot.
  assign wait_end  = (state_q == RX_WAIT) && (cnt == WAIT_LAST);
  assign slot_end  = (state_q == RX_SLOT) && (cnt == SLOT_LAST);
  assign sample_pt = (state_q == RX_SLOT) && (cnt == SAMPLE_AT);
  assign abort_now = sample_pt && !rx_bit && resp_empty;
  assign full_now  = sample_pt && !abort_now && resp_last;
  assign shift_en  = sample_pt && !abort_now && !start_i;

  // One counter serves both the holdoff and the slot position.
  assign tmr_clr = start_i || wait_end || slot_end || abort_now || full_now;
  assign tmr_en  = (state_q != RX_IDLE);

  rrx_timer #(
    .CW (CW)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (tmr_clr),
    .en_i  (tmr_en),
    .cnt_o (cnt)
  );

  rrx_shifter #(
    .N  (MAX_BITS),
    .LW (LEN_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (start_i),
    .shift_i (shift_en),
    .bit_i   (rx_bit),
    .resp_o  (resp_o),
    .len_o   (len_o),
    .empty_o (resp_empty),
    .last_o  (resp_last)
  );

  // Sequencing. A start pulse wins over everything else.
  always_comb begin
    state_d = state_q;
    if (start_i) begin
      state_d = RX_WAIT;
    end else begin
      unique case (state_q)
        RX_WAIT: if (wait_end) state_d = RX_SLOT;
        RX_SLOT: if (abort_now || full_now) state_d = RX_IDLE;
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RX_IDLE;
    else        state_q <= state_d;
  end

  // Completion pulse and abort status.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      done_q <= !start_i && (abort_now || full_now);
      if (start_i)        abort_q <= 1'b0;
      else if (abort_now) abort_q <= 1'b1;
    end
  end

  assign done_o  = done_q;
  assign abort_o = abort_q;

  // The rail is low from the start of each slot until the restore delay
  // after the sample has passed. A final or aborting sample moves to idle,
  // so power returns at once.
  assign rail_pwr_o = !((state_q == RX_SLOT) && (cnt < LOW_CYCLES));

endmodule

// File: rtl/rail_resp_rx_chk.sv
module rail_resp_rx_chk #(
  parameter int unsigned MAX_BITS = 15,
  parameter int unsigned LEN_W    = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                rail_pwr_o,
  input logic [MAX_BITS-1:0] resp_o,
  input logic [LEN_W-1:0]    len_o,
  input logic                done_o,
  input logic                abort_o
);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> rail_pwr_o);

  // R10
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_o <= LEN_W'(MAX_BITS));

  // R7
  abort_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (len_o == '0 && resp_o == '0));

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (len_o == '0 && resp_o == '0 && !abort_o && rail_pwr_o));

  // R5
  len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_o != $past(len_o)) |-> (len_o == $past(len_o) + LEN_W'(1) || len_o == '0));

endmodule

bind rail_resp_rx rail_resp_rx_chk #(
  .MAX_BITS (MAX_BITS),
  .LEN_W    (LEN_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .rail_pwr_o (rail_pwr_o),
  .resp_o     (resp_o),
  .len_o      (len_o),
  .done_o     (done_o),
  .abort_o    (abort_o)
);

// File: tb/rail_resp_rx_test.sv
module rail_resp_rx_test;

  localparam int CLK_PERIOD = 10;
  localparam int DELAY   = 20;
  localparam int SLOT    = 12;
  localparam int SAMPLE  = 3;
  localparam int RESTORE = 2;
  localparam int MAXB    = 6;
  localparam int LW      = $clog2(MAXB + 1);
  localparam int WINDOW  = DELAY + (MAXB + 2) * SLOT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic det;
  logic rail;
  logic [MAXB-1:0] resp;
  logic [LW-1:0] len;
  logic done, abrt;

  logic [MAXB-1:0] pat = '0;
  int slot_idx = 0;
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic cur_bit;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Rail model: detect is high while powered; when pulled low it shows the
  // reply bit (logic 1 = low level).
  assign cur_bit = (slot_idx < MAXB) ? pat[slot_idx] : 1'b0;
  assign det = rail ? 1'b1 : ~cur_bit;

  rail_resp_rx #(
    .DELAY_CYC(DELAY), .SLOT_CYC(SLOT), .SAMPLE_CYC(SAMPLE),
    .RESTORE_CYC(RESTORE), .MAX_BITS(MAXB), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .det_i(det),
    .rail_pwr_o(rail), .resp_o(resp), .len_o(len), .done_o(done), .abort_o(abrt)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic issue_start(input logic [MAXB-1:0] p);
    @(negedge clk);
    start = 1'b1;
    pat = p;
    slot_idx = 0;
  endtask

  // Runs one reception with reply pattern p (bit i goes out in slot i).
  task automatic run_pattern(input logic [MAXB-1:0] p);
    int t0, first_fall, last_fall, falls, low_len, dones;
    logic prev_rail;
    logic [MAXB-1:0] exp_resp;
    bit exp_abort;
    issue_start(p);
    t0 = cyc;
    @(negedge clk);
    start = 1'b0;
    // R2: cleared right after the start edge
    check(len == 0 && resp == 0 && !abrt, "R2", "clear after start", int'(len), 0);
    check(rail == 1'b1, "R2", "rail powered in holdoff", int'(rail), 1);
    exp_abort = (p[0] == 1'b0);
    exp_resp = '0;
    for (int i = 0; i < MAXB; i++) exp_resp[MAXB-1-i] = p[i];
    if (exp_abort) exp_resp = '0;
    first_fall = -1; last_fall = -1; falls = 0; low_len = 0; dones = 0;
    prev_rail = 1'b1;
    for (int n = 0; n < WINDOW; n++) begin
      if (n > 0) @(negedge clk);
      if (!rail && prev_rail) begin
        falls++;
        if (first_fall < 0) first_fall = cyc;
        else check(cyc - last_fall == SLOT, "R3", "slot spacing", cyc - last_fall, SLOT);
        last_fall = cyc;
        low_len = 0;
      end
      if (!rail) low_len++;
      if (rail && !prev_rail) begin
        slot_idx++;
        if (done)
          check(low_len == SAMPLE, "R8", "final low length", low_len, SAMPLE);
        else
          check(low_len == SAMPLE + RESTORE, "R6", "low length", low_len, SAMPLE + RESTORE);
      end
      if (done) dones++;
      prev_rail = rail;
    end
    check(first_fall == t0 + DELAY + 1, "R3", "first drop", first_fall, t0 + DELAY + 1);
    check(dones == 1, "R9", "done pulses", dones, 1);
    check(abrt == exp_abort, "R7", "abort flag", int'(abrt), int'(exp_abort));
    check(falls == (exp_abort ? 1 : MAXB), "R8", "slot count", falls, exp_abort ? 1 : MAXB);
    check(resp == exp_resp, "R5", "response", int'(resp), int'(exp_resp));
    check(int'(len) == (exp_abort ? 0 : MAXB), "R10", "length", int'(len), exp_abort ? 0 : MAXB);
    check(rail == 1'b1, "R9", "rail held on", int'(rail), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rail == 1'b1 && done == 1'b0 && abrt == 1'b0, "R1", "reset controls", int'(rail), 1);
    check(resp == 0 && len == 0, "R1", "reset data", int'(resp), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R4/R5/R6/R7/R8: every reply pattern
    for (int p = 0; p < (1 << MAXB); p++) run_pattern(MAXB'(p));
    // R2: restart in the middle of a reception
    issue_start(6'b111111);
    @(negedge clk);
    start = 1'b0;
    repeat (DELAY + 2 * SLOT - 1) @(negedge clk);
    check(int'(len) == 2, "R5", "partial length before restart", int'(len), 2);
    run_pattern(6'b010101);
    run_pattern(6'b000001);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule